// File: doc/BRIEF.md
# PCM Time-Slot Bus Interface

This block attaches four voice channels to a time-division serial PCM bus that uses one pin per direction. A one-cycle frame strobe starts each frame. After the strobe the block counts bit clocks into 8-bit slots. When a slot is programmed as a channel's transmit slot, the block shifts that channel's byte out on the transmit pin, most significant bit first, and raises an output enable. When a slot is programmed as a channel's receive slot, the block shifts the receive pin into that channel's byte register. It then presents the finished byte with a one-cycle valid pulse.

A channel's transmit slot and receive slot are set independently, anywhere in a frame of up to 256 slots. No slot count is fixed: the frame length is simply the time between strobes, so slower buses work. Transmit bytes come from a parallel holding input, which is copied into a frame buffer at each strobe. A small write port sets the slot numbers and the enable of each channel.

Top module: `pcm_slot_if`

## Requirements
- R1: After reset all channels are disabled with both slot numbers 0, `tx_oe` and `rx_valid` are 0, and `rx_byte` is all zero.
- R2: A rising edge that samples `fs` high puts the block at bit 0 of slot 0 in the following clock period.
- R3: During the 8 bit periods of its transmit slot, an enabled channel drives its byte on `tx_data`, most significant bit first. Each new bit appears just after a rising edge.
- R4: `tx_oe` is 1 only during slots owned by an enabled channel. While `tx_oe` is 0, `tx_data` is 0.
- R5: If several enabled channels share a transmit slot, the one with the lowest index drives the slot. A disabled channel never takes part in this choice.
- R6: The transmitted byte is the value of `tx_hold` at the strobe edge. Changes to `tx_hold` later in the frame take effect only from the next strobe.
- R7: `rx_data` is sampled on falling edges. After the rising edge that ends bit 7 of a channel's receive slot, `rx_byte` for that channel holds the 8 sampled bits, first bit in the MSB, and `rx_valid` for that channel is high for exactly one cycle.
- R8: The transmit slot and receive slot of each channel are independent, and any value from 0 to 255 is valid for either one, including slot 255 in a 256-slot frame.
- R9: A disabled channel produces no `rx_valid` pulse and leaves its `rx_byte` unchanged.
- R10: From reset until the first strobe, the block drives nothing and captures nothing.
- R11: The frame length is set only by the spacing of the strobes. With a short frame, slot 0 starts again at each strobe.
- R12: A write with `cfg_we` high uses `cfg_kind` as follows: 0 sets the transmit slot of channel `cfg_ch` to `cfg_data`, 1 sets its receive slot, and 2 sets its enable to `cfg_data[0]`. Kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame strobe, one cycle wide |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_kind | input | 2 | Field selected by the write (0 tx slot, 1 rx slot, 2 enable, 3 none) |
| cfg_data | input | 8 | Write data |
| tx_hold | input | 32 | Transmit holding bytes, channel n in bits 8n+7:8n |
| tx_data | output | 1 | Outbound serial data |
| tx_oe | output | 1 | Output enable for the transmit pin driver |
| rx_data | input | 1 | Inbound serial data |
| rx_byte | output | 32 | Received bytes, channel n in bits 8n+7:8n |
| rx_valid | output | 4 | One-cycle pulse for each channel with a new byte |

## Verification
Several properties are checked on every cycle. While the output enable is low, the transmit pin stays low. Nothing is driven or captured before the first strobe. A strobe restarts the bit and slot position. The position moves forward by one bit per clock. A receive valid pulse follows only a last-bit period and lasts one cycle. Other behaviour can only be shown by running frames in the bench: the byte values and their bit order, which channel wins a shared slot, the copy of the holding bytes at the strobe, slot 255, short frames, and the decoding of the write kinds.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int SLOT_W = 8;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        CFG_TX_SLOT = 2'd0,
        CFG_RX_SLOT = 2'd1,
        CFG_ENABLE  = 2'd2,
        CFG_NONE    = 2'd3
    } cfg_kind_e;

    // Position inside the frame; synced is set by the first strobe.
    typedef struct packed {
        logic             synced;
        slot_t            slot;
        logic [BIT_W-1:0] bit_idx;
    } pos_t;

    function automatic logic pos_is_last(pos_t p);
        return p.bit_idx == BIT_LAST;
    endfunction

    // Most significant bit goes first on the wire.
    function automatic logic wire_bit(byte_t b, logic [BIT_W-1:0] idx);
        return b[BIT_LAST - idx];
    endfunction

endpackage

// File: rtl/pcm_cfg_regs.sv
module pcm_cfg_regs
    import pcm_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [CH_W-1:0] ch,
    input  cfg_kind_e       kind,
    input  slot_t           data,
    output logic [NCH-1:0]  ch_en,
    output slot_t           tx_slot [NCH],
    output slot_t           rx_slot [NCH]
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ch_en[g]   <= 1'b0;
                tx_slot[g] <= '0;
                rx_slot[g] <= '0;
            end else if (we && ch == CH_W'(g)) begin
                case (kind)
                    CFG_TX_SLOT: tx_slot[g] <= data;
                    CFG_RX_SLOT: rx_slot[g] <= data;
                    CFG_ENABLE:  ch_en[g]   <= data[0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pcm_slot_cnt.sv
module pcm_slot_cnt
    import pcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fs,
    output pos_t pos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (fs) begin
            pos.synced  <= 1'b1;
            pos.slot    <= '0;
            pos.bit_idx <= '0;
        end else if (pos.synced) begin
            pos.bit_idx <= pos.bit_idx + 1'b1;
            if (pos_is_last(pos)) begin
                pos.slot <= pos.slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fs,
    input  pos_t                  pos,
    input  logic [NCH*BYTE_W-1:0] hold,
    input  logic [NCH-1:0]        ch_en,
    input  slot_t                 tx_slot [NCH],
    output logic                  tx_data,
    output logic                  tx_oe
);

    byte_t            frame_buf [NCH];
    logic             hit;
    logic [CH_W-1:0]  own;

    // Second buffer stage: copy of the holding bytes taken at each strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) frame_buf[i] <= '0;
        end else if (fs) begin
            for (int i = 0; i < NCH; i++) frame_buf[i] <= hold[i*BYTE_W +: BYTE_W];
        end
    end

    // Highest index is visited first, so the lowest index ends up owning.
    always_comb begin
        hit = 1'b0;
        own = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_en[i] && tx_slot[i] == pos.slot) begin
                hit = 1'b1;
                own = CH_W'(i);
            end
        end
    end

    assign tx_oe   = pos.synced & hit;
    assign tx_data = tx_oe & wire_bit(frame_buf[own], pos.bit_idx);

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_data,
    input  pos_t           pos,
    input  logic [NCH-1:0] ch_en,
    input  slot_t          rx_slot [NCH],
    output byte_t          rx_byte [NCH],
    output logic [NCH-1:0] rx_valid
);

    logic rx_smp;

    // Pin sampled mid-bit, on the falling edge.
    always_ff @(negedge clk) begin
        rx_smp <= rx_data;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [BYTE_W-2:0] shift_q;
        logic              mine;

        assign mine = pos.synced && ch_en[g] && rx_slot[g] == pos.slot;

        always_ff @(posedge clk) begin
            if (rst) begin
                shift_q     <= '0;
                rx_byte[g]  <= '0;
                rx_valid[g] <= 1'b0;
            end else begin
                rx_valid[g] <= 1'b0;
                if (mine) begin
                    if (pos_is_last(pos)) begin
                        rx_byte[g]  <= {shift_q, rx_smp};
                        rx_valid[g] <= 1'b1;
                    end else begin
                        shift_q <= {shift_q[BYTE_W-3:0], rx_smp};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if
    import pcm_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fs,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [1:0]            cfg_kind,
    input  logic [SLOT_W-1:0]     cfg_data,
    input  logic [NCH*BYTE_W-1:0] tx_hold,
    output logic                  tx_data,
    output logic                  tx_oe,
    input  logic                  rx_data,
    output logic [NCH*BYTE_W-1:0] rx_byte,
    output logic [NCH-1:0]        rx_valid
);

    pos_t           pos;
    logic [NCH-1:0] ch_en;
    slot_t          tx_slot [NCH];
    slot_t          rx_slot [NCH];
    byte_t          rx_arr  [NCH];

    pcm_slot_cnt u_cnt (
        .clk (clk),
        .rst (rst),
        .fs  (fs),
        .pos (pos)
    );

    pcm_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .ch      (cfg_ch),
        .kind    (cfg_kind_e'(cfg_kind)),
        .data    (cfg_data),
        .ch_en   (ch_en),
        .tx_slot (tx_slot),
        .rx_slot (rx_slot)
    );

    pcm_tx_path #(.NCH(NCH)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .fs      (fs),
        .pos     (pos),
        .hold    (tx_hold),
        .ch_en   (ch_en),
        .tx_slot (tx_slot),
        .tx_data (tx_data),
        .tx_oe   (tx_oe)
    );

    pcm_rx_path #(.NCH(NCH)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .pos      (pos),
        .ch_en    (ch_en),
        .rx_slot  (rx_slot),
        .rx_byte  (rx_arr),
        .rx_valid (rx_valid)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign rx_byte[g*BYTE_W +: BYTE_W] = rx_arr[g];
    end

endmodule

// File: rtl/pcm_slot_if_chk.sv
module pcm_slot_if_chk
    import pcm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           fs,
    input logic           tx_data,
    input logic           tx_oe,
    input logic [NCH-1:0] rx_valid,
    input pos_t           pos
);

    // R4: pin driver idles low when not enabled
    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_data);

    // R10: nothing happens before the first strobe
    a_r10_unsynced_quiet: assert property (@(posedge clk) disable iff (rst)
        !pos.synced |-> (!tx_oe && rx_valid == '0));

    // R2: strobe restarts the frame position
    a_r2_fs_restart: assert property (@(posedge clk) disable iff (rst)
        fs |=> (pos.synced && pos.slot == '0 && pos.bit_idx == '0));

    // R11: one bit per clock between strobes
    a_r11_bit_advance: assert property (@(posedge clk) disable iff (rst)
        (!fs && pos.synced) |=> pos.bit_idx == BIT_W'($past(pos.bit_idx) + 1'b1));

    // R7: a byte is reported only after a last-bit period
    a_r7_valid_after_last: assert property (@(posedge clk) disable iff (rst)
        (|rx_valid) |-> $past(pos.bit_idx) == BIT_LAST);

    // R7: valid lasts one cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        (|rx_valid) |=> rx_valid == '0);

endmodule

bind pcm_slot_if pcm_slot_if_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fs       (fs),
    .tx_data  (tx_data),
    .tx_oe    (tx_oe),
    .rx_valid (rx_valid),
    .pos      (pos)
);

// File: tb/pcm_slot_if_tb.sv
module pcm_slot_if_tb_top;

    localparam int NCH = 4;

    typedef struct packed {
        logic [3:0]  en;
        logic [31:0] txs;   // channel n slot in bits 8n+7:8n
        logic [31:0] rxs;
        logic [8:0]  nsl;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{en: 4'hF,    txs: 32'h03020100, rxs: 32'h00010203, nsl: 9'd8},
        '{en: 4'hF,    txs: 32'h05050505, rxs: 32'h09080706, nsl: 9'd12},
        '{en: 4'b1010, txs: 32'h04040101, rxs: 32'h05050202, nsl: 9'd8},
        '{en: 4'hF,    txs: 32'h01020003, rxs: 32'h02010300, nsl: 9'd4},
        '{en: 4'hF,    txs: 32'h28640AFF, rxs: 32'hFA073C96, nsl: 9'd256}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_kind = '0;
    logic [7:0]  cfg_data = '0;
    logic [31:0] hold_q = '0;
    logic        rx_d = 1'b0;
    logic        tx_data, tx_oe;
    logic [31:0] rx_byte;
    logic [3:0]  rx_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_en  [NCH];
    logic [7:0] m_tx  [NCH];
    logic [7:0] m_rx  [NCH];
    logic [7:0] fbuf  [NCH];
    int         frame_id = 0;

    always #2 clk = ~clk;

    pcm_slot_if #(.NCH(NCH)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .fs       (fs),
        .cfg_we   (cfg_we),
        .cfg_ch   (cfg_ch),
        .cfg_kind (cfg_kind),
        .cfg_data (cfg_data),
        .tx_hold  (hold_q),
        .tx_data  (tx_data),
        .tx_oe    (tx_oe),
        .rx_data  (rx_d),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(int f, int s);
        return 8'(s * 29 + f * 7 + 90);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_en[i] = 1'b0; m_tx[i] = '0; m_rx[i] = '0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        model_reset();
    endtask

    task automatic cfg_write(input int ch, input int kind, input int data);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_kind = 2'(kind); cfg_data = 8'(data);
        tick();
        cfg_we = 1'b0;
        case (kind)
            0: m_tx[ch] = 8'(data);
            1: m_rx[ch] = 8'(data);
            2: m_en[ch] = data[0];
            default: ;
        endcase
    endtask

    task automatic run_frame(input int nsl, input bit scramble, input string rtag);
        logic [31:0] snap;
        snap = rx_byte;
        fs = 1'b1;
        tick();
        fs = 1'b0;
        frame_id++;
        for (int i = 0; i < NCH; i++) fbuf[i] = hold_q[i*8 +: 8];
        for (int c = 0; c <= nsl * 8; c++) begin
            int s, b, own, cnt;
            logic eoe, ed;
            logic [3:0] ev;
            logic [7:0] p;
            string tag;
            s = c / 8; b = c % 8;
            if (c < nsl * 8) begin
                own = -1; cnt = 0;
                for (int i = NCH - 1; i >= 0; i--) begin
                    if (m_en[i] && m_tx[i] == 8'(s)) begin own = i; cnt++; end
                end
                eoe = (own >= 0);
                ed  = eoe ? fbuf[own][7 - b] : 1'b0;
                if (cnt > 1)      tag = "R5";
                else if (!eoe)    tag = "R4";
                else if (c == 0)  tag = "R2";
                else if (scramble) tag = "R6";
                else              tag = rtag;
                check(tx_oe == eoe && tx_data == ed, tag, {30'd0, tx_oe, tx_data}, {30'd0, eoe, ed});
            end
            if (c > 0 && b == 0) begin
                ev = '0;
                for (int i = 0; i < NCH; i++) if (m_en[i] && m_rx[i] == 8'(s - 1)) ev[i] = 1'b1;
                check(rx_valid == ev, "R7", {28'd0, rx_valid}, {28'd0, ev});
                for (int i = 0; i < NCH; i++) begin
                    if (ev[i]) check(rx_byte[i*8 +: 8] == pat(frame_id, s - 1), "R8",
                                     {24'd0, rx_byte[i*8 +: 8]}, {24'd0, pat(frame_id, s - 1)});
                end
            end
            if (scramble && c == 1) hold_q = hold_q ^ 32'hA5C3961E;
            p = pat(frame_id, s);
            rx_d = (c < nsl * 8) ? p[7 - b] : 1'b0;
            if (c < nsl * 8) tick();
        end
        for (int i = 0; i < NCH; i++) begin
            if (!m_en[i]) check(rx_byte[i*8 +: 8] == snap[i*8 +: 8], "R9",
                                {24'd0, rx_byte[i*8 +: 8]}, {24'd0, snap[i*8 +: 8]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state at the ports
        check(tx_oe == 1'b0, "R1", {31'd0, tx_oe}, 32'd0);
        check(rx_valid == '0, "R1", {28'd0, rx_valid}, 32'd0);
        check(rx_byte == '0, "R1", rx_byte, 32'd0);
        // R1: defaults leave every channel silent
        hold_q = 32'hFFFFFFFF;
        run_frame(4, 1'b0, "R1");

        // R10: enabled channel before any strobe stays quiet
        do_reset();
        cfg_write(0, 0, 0);
        cfg_write(0, 1, 0);
        cfg_write(0, 2, 1);
        for (int k = 0; k < 40; k++) begin
            rx_d = k[0];
            tick();
            check(tx_oe == 1'b0 && rx_valid == '0, "R10", {27'd0, tx_oe, rx_valid}, 32'd0);
        end

        // Vector table: configuration, then two frames each
        for (int v = 0; v < NVEC; v++) begin
            hold_q = 32'(32'h13579BDF * (v + 3));
            for (int i = 0; i < NCH; i++) begin
                cfg_write(i, 0, int'(VECS[v].txs[i*8 +: 8]));
                cfg_write(i, 1, int'(VECS[v].rxs[i*8 +: 8]));
                cfg_write(i, 2, int'(VECS[v].en[i]));
            end
            run_frame(int'(VECS[v].nsl), 1'b1, (VECS[v].nsl < 8) ? "R11" : "R3");
            run_frame(int'(VECS[v].nsl), 1'b0, (VECS[v].nsl < 8) ? "R11" : "R8");
        end

        // R12: kind 3 changes nothing
        cfg_write(0, 0, 2);
        cfg_write(0, 2, 1);
        cfg_write(0, 3, 0);
        cfg_write(1, 3, 2);
        run_frame(4, 1'b0, "R12");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule